// File: doc/BRIEF.md
# Disk Frame Header Stripper

This block sits between two FIFOs in a playback path. Its input is a stream of 32-bit words laid out as fixed-size disk frames: a four-word header followed by a block of data words. It takes the header words out of the stream, checks that each one carries the sync constant in the right place and a frame serial number that follows the expected sequence, and passes only the data words downstream. Each data word leaves with two tags. One says whether the word is trustworthy. The other marks the first word of a second of recorded time.

Two programmable sentinel words mark samples that the recording chain flagged as bad. Any word equal to either sentinel is tagged as not valid. A header word that equals a sentinel cannot be checked, so it is accepted as it stands. An internal frame counter supplies the expected serial number, so the timing keeps running through such headers. At the first frame of each second, the block pulses an interrupt, captures the two time-code header words and advances a 16-bit seconds counter. On the first broken header it stops taking input for good and raises a sticky error flag and an error lamp output.

Top module: `frame_hdr_strip`

## Requirements
- R1: A frame is 4 header words followed by DATA_WORDS data words. Only the data words appear on the output, in their input order. Header words are consumed and never emitted.
- R2: Header word 0 (position 0 of a frame) must equal SYNC_WORD. If it differs and matches no sentinel, a header error is raised.
- R3: Header word 1 carries the frame count in its low CNT_W bits, with all upper bits zero. The expected count rises by one per frame and returns to 0 after the value fps_limit-1. Any other value that matches no sentinel is a header error.
- R4: The first frame after reset must carry count 0. A different value is a header error.
- R5: After a header error, hdr_err and err_led are high and stay high until reset. in_ready stays low, and no word of the broken frame or any later frame reaches the output.
- R6: out_ok is 0 for a data word equal to inv_code_a or inv_code_b, and 1 otherwise.
- R7: A header word equal to either sentinel is not checked and raises no error. The internal frame counter still advances, so later frames are checked against the correct sequence.
- R8: In a frame whose expected count is 0, sos_irq pulses high for exactly one cycle. Header words 2 and 3 of that frame are captured into tcode0 and tcode1.
- R9: sec_count increments by one at each count-0 frame and wraps modulo 2^SEC_W. It reads 1 after the first frame following reset.
- R10: out_sos is 1 only on the first data word of a count-0 frame.
- R11: Both sides use valid/ready handshakes. While out_valid is high and out_ready is low, the output word and its tags hold steady. No word is dropped or duplicated.
- R12: While enable is low, in_ready is low and no input is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Allows words to be taken from the input |
| fps_limit | input | CNT_W | Frames per second of recording |
| inv_code_a | input | WORD_W | First sentinel word |
| inv_code_b | input | WORD_W | Second sentinel word |
| in_valid | input | 1 | Input word present |
| in_data | input | WORD_W | Input word |
| in_ready | output | 1 | Block takes the input word this cycle |
| out_valid | output | 1 | Output word present |
| out_data | output | WORD_W | Output data word |
| out_ok | output | 1 | Output word is valid (matches no sentinel) |
| out_sos | output | 1 | Output word starts a second |
| out_ready | input | 1 | Downstream accepts the output word |
| sos_irq | output | 1 | One-cycle start-of-second pulse |
| tcode0 | output | WORD_W | Captured header word 2 of the last count-0 frame |
| tcode1 | output | WORD_W | Captured header word 3 of the last count-0 frame |
| sec_count | output | SEC_W | Seconds counter |
| hdr_err | output | 1 | Sticky header error |
| err_led | output | 1 | Error lamp drive |

## Verification
On every cycle, the assertions check four things: that the error halts input and stays set, that the output holds steady under backpressure, that the interrupt is a single-cycle pulse tied to a one-step rise of the seconds counter, and that input is gated while the block is disabled. The following can only be shown by the bench scenarios, which compare against a model of the frame sequence: the correct removal of headers, the sentinel tagging of data and header words, the placement of the start-of-second tag, the captured time codes, and the detection of a bad sync, a bad first count, a skipped count and a late wrap.

// File: rtl/fhs_pkg.sv
package fhs_pkg;

   // Fixed header length; the slot order is decoded by the checker.
   localparam int HDR_WORDS = 4;

   typedef enum logic [1:0] {
      SLOT_SYNC  = 2'd0,
      SLOT_COUNT = 2'd1,
      SLOT_TIME0 = 2'd2,
      SLOT_TIME1 = 2'd3
   } hdr_slot_e;

   // Next expected frame count with wrap at the per-second limit.
   function automatic logic [31:0] next_frame_count(input logic [31:0] cur,
                                                    input logic [31:0] limit);
      logic [32:0] inc;
      inc = {1'b0, cur} + 33'd1;
      return (inc >= {1'b0, limit}) ? 32'd0 : inc[31:0];
   endfunction

endpackage

// File: rtl/fhs_code_match.sv
module fhs_code_match #(
   parameter int W = 32,
   parameter int N = 2
) (
   input  logic [N*W-1:0] codes,
   input  logic [W-1:0]   word,
   output logic           hit
);
   logic [N-1:0] hits;

   generate
      if (N < 1) begin : g_bad_n
         $error("fhs_code_match needs at least one code");
      end
      for (genvar g = 0; g < N; g++) begin : g_cmp
         assign hits[g] = (word == codes[g*W +: W]);
      end
   endgenerate

   assign hit = |hits;
endmodule

// File: rtl/fhs_frame_pos.sv
module fhs_frame_pos
   import fhs_pkg::*;
#(
   parameter int DATA_WORDS = 2500,
   localparam int FRAME_WORDS = HDR_WORDS + DATA_WORDS,
   localparam int POS_W = $clog2(FRAME_WORDS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   output logic [POS_W-1:0] pos,
   output logic             is_hdr,
   output logic             first_data,
   output logic             last_word,
   output hdr_slot_e        slot
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pos <= '0;
      end else if (step) begin
         pos <= last_word ? '0 : pos + 1'b1;
      end
   end

   assign is_hdr     = (pos < POS_W'(HDR_WORDS));
   assign first_data = (pos == POS_W'(HDR_WORDS));
   assign last_word  = (pos == POS_W'(FRAME_WORDS - 1));
   assign slot       = hdr_slot_e'(pos[1:0]);
endmodule

// File: rtl/fhs_hdr_check.sv
module fhs_hdr_check
   import fhs_pkg::*;
#(
   parameter int          W         = 32,
   parameter int          CW        = 16,
   parameter int          SW        = 16,
   parameter logic [W-1:0] SYNC_WORD = 32'hC0DE_5A5A
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          take,
   input  logic          is_hdr,
   input  hdr_slot_e     slot,
   input  logic          last_word,
   input  logic [W-1:0]  word,
   input  logic          marked,
   input  logic [CW-1:0] fps_limit,
   output logic          sos_frame,
   output logic          hdr_err,
   output logic          sos_irq,
   output logic [W-1:0]  tcode0,
   output logic [W-1:0]  tcode1,
   output logic [SW-1:0] sec_count
);
   logic [CW-1:0] exp_cnt;
   logic [CW:0]   exp_inc;
   logic          wrap;
   logic          at_sync, at_count, at_t0, at_t1;
   logic          bad_sync, bad_count;

   generate
      if (CW > W) begin : g_bad_cw
         $error("frame count wider than a word");
      end
   endgenerate

   assign at_sync  = take && is_hdr && (slot == SLOT_SYNC);
   assign at_count = take && is_hdr && (slot == SLOT_COUNT);
   assign at_t0    = take && is_hdr && (slot == SLOT_TIME0);
   assign at_t1    = take && is_hdr && (slot == SLOT_TIME1);

   assign sos_frame = (exp_cnt == '0);

   // Sentinel-matching header words are trusted as they stand.
   assign bad_sync  = at_sync  && !marked && (word != SYNC_WORD);
   assign bad_count = at_count && !marked && (word != W'(exp_cnt));

   assign exp_inc = {1'b0, exp_cnt} + 1'b1;
   assign wrap    = (exp_inc >= {1'b0, fps_limit});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exp_cnt   <= '0;
         hdr_err   <= 1'b0;
         sos_irq   <= 1'b0;
         tcode0    <= '0;
         tcode1    <= '0;
         sec_count <= '0;
      end else begin
         if (take && last_word) begin
            exp_cnt <= wrap ? '0 : exp_inc[CW-1:0];
         end
         if (bad_sync || bad_count) begin
            hdr_err <= 1'b1;
         end
         sos_irq <= at_count && sos_frame && !bad_count;
         if (at_count && sos_frame && !bad_count) begin
            sec_count <= sec_count + 1'b1;
         end
         if (at_t0 && sos_frame) begin
            tcode0 <= word;
         end
         if (at_t1 && sos_frame) begin
            tcode1 <= word;
         end
      end
   end
endmodule

// File: rtl/frame_hdr_strip.sv
module frame_hdr_strip
   import fhs_pkg::*;
#(
   parameter int               WORD_W     = 32,
   parameter int               DATA_WORDS = 2500,
   parameter int               CNT_W      = 16,
   parameter int               SEC_W      = 16,
   parameter logic [WORD_W-1:0] SYNC_WORD = 32'hC0DE_5A5A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic [CNT_W-1:0]  fps_limit,
   input  logic [WORD_W-1:0] inv_code_a,
   input  logic [WORD_W-1:0] inv_code_b,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [WORD_W-1:0] out_data,
   output logic              out_ok,
   output logic              out_sos,
   input  logic              out_ready,
   output logic              sos_irq,
   output logic [WORD_W-1:0] tcode0,
   output logic [WORD_W-1:0] tcode1,
   output logic [SEC_W-1:0]  sec_count,
   output logic              hdr_err,
   output logic              err_led
);
   localparam int FRAME_WORDS = HDR_WORDS + DATA_WORDS;
   localparam int POS_W       = $clog2(FRAME_WORDS);

   generate
      if (DATA_WORDS < 2) begin : g_bad_len
         $error("frame needs at least two data words");
      end
      if (WORD_W < 8) begin : g_bad_w
         $error("word width too small");
      end
   endgenerate

   logic [POS_W-1:0] pos;
   logic             is_hdr, first_data, last_word;
   hdr_slot_e        slot;
   logic             marked, take, sos_frame, room;

   fhs_code_match #(.W(WORD_W), .N(2)) u_match (
      .codes ({inv_code_b, inv_code_a}),
      .word  (in_data),
      .hit   (marked)
   );

   fhs_frame_pos #(.DATA_WORDS(DATA_WORDS)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .step       (take),
      .pos        (pos),
      .is_hdr     (is_hdr),
      .first_data (first_data),
      .last_word  (last_word),
      .slot       (slot)
   );

   fhs_hdr_check #(
      .W(WORD_W), .CW(CNT_W), .SW(SEC_W), .SYNC_WORD(SYNC_WORD)
   ) u_chk (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .is_hdr    (is_hdr),
      .slot      (slot),
      .last_word (last_word),
      .word      (in_data),
      .marked    (marked),
      .fps_limit (fps_limit),
      .sos_frame (sos_frame),
      .hdr_err   (hdr_err),
      .sos_irq   (sos_irq),
      .tcode0    (tcode0),
      .tcode1    (tcode1),
      .sec_count (sec_count)
   );

   // Header words need no output slot; data words need the register free.
   assign room     = is_hdr || !out_valid || out_ready;
   assign in_ready = enable && !hdr_err && room;
   assign take     = in_valid && in_ready;
   assign err_led  = hdr_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_data  <= '0;
         out_ok    <= 1'b0;
         out_sos   <= 1'b0;
      end else if (take && !is_hdr) begin
         out_valid <= 1'b1;
         out_data  <= in_data;
         out_ok    <= !marked;
         out_sos   <= first_data && sos_frame;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   logic unused_pos;
   assign unused_pos = ^pos;
endmodule

// File: rtl/fhs_checker.sv
module fhs_checker #(
   parameter int W  = 32,
   parameter int SW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          enable,
   input logic          in_ready,
   input logic          out_valid,
   input logic          out_ready,
   input logic [W-1:0]  out_data,
   input logic          out_ok,
   input logic          out_sos,
   input logic          sos_irq,
   input logic [SW-1:0] sec_count,
   input logic          hdr_err
);
   assert_hold_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
                                     $stable(out_ok) && $stable(out_sos)));

   assert_halt_input_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |-> !in_ready);

   assert_err_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      hdr_err |=> hdr_err);

   assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sos_irq |=> !sos_irq);

   assert_sec_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sos_irq) |-> (sec_count == SW'($past(sec_count) + 1'b1)));

   assert_sec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !sos_irq |-> $stable(sec_count));

   assert_gate_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |-> !in_ready);
endmodule

bind frame_hdr_strip fhs_checker #(.W(WORD_W), .SW(SEC_W)) u_fhs_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .enable    (enable),
   .in_ready  (in_ready),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_data  (out_data),
   .out_ok    (out_ok),
   .out_sos   (out_sos),
   .sos_irq   (sos_irq),
   .sec_count (sec_count),
   .hdr_err   (hdr_err)
);

// File: tb/frame_hdr_strip_test.sv
module frame_hdr_strip_test;
   localparam int          W    = 32;
   localparam int          DW   = 6;
   localparam int          CW   = 16;
   localparam int          SW   = 16;
   localparam logic [31:0] SYNC = 32'hC0DE_5A5A;
   localparam logic [31:0] CA   = 32'hDEAD_0001;
   localparam logic [31:0] CB   = 32'hDEAD_0002;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic          rst_n, enable, in_valid, in_ready, out_valid, out_ready;
   logic          out_ok, out_sos, sos_irq, hdr_err, err_led;
   logic [CW-1:0] fps_limit;
   logic [W-1:0]  in_data, out_data, tcode0, tcode1;
   logic [SW-1:0] sec_count;

   frame_hdr_strip #(.WORD_W(W), .DATA_WORDS(DW), .CNT_W(CW), .SEC_W(SW),
                     .SYNC_WORD(SYNC)) uut (
      .clk(clk), .rst_n(rst_n), .enable(enable), .fps_limit(fps_limit),
      .inv_code_a(CA), .inv_code_b(CB), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ok(out_ok), .out_sos(out_sos), .out_ready(out_ready),
      .sos_irq(sos_irq), .tcode0(tcode0), .tcode1(tcode1),
      .sec_count(sec_count), .hdr_err(hdr_err), .err_led(err_led)
   );

   int checks = 0;
   int fails  = 0;
   logic [31:0] stim [0:255];
   logic [31:0] xdata[0:255];
   logic        xok  [0:255];
   logic        xsos [0:255];
   int nstim, nexp, bcnt, sos_seen, fidx;

   task automatic chk(input bit ok, input string req,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   initial begin
      #1500000;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_up();
   end

   task automatic clear_stream();
      nstim = 0; nexp = 0; bcnt = 0; fidx = 0;
   endtask

   // Appends one frame; keep=1 means its data is expected at the output.
   task automatic add_frame(input logic [31:0] w0, input logic [31:0] w1, input bit keep);
      logic [31:0] w;
      stim[nstim] = w0;                       nstim++;
      stim[nstim] = w1;                       nstim++;
      stim[nstim] = 32'h7100_0000 + fidx * 2; nstim++;
      stim[nstim] = 32'h7100_0001 + fidx * 2; nstim++;
      for (int d = 0; d < DW; d++) begin
         w = $urandom;
         case ($urandom % 5)
            0: w = CA;
            1: w = CB;
            default: ;
         endcase
         stim[nstim] = w; nstim++;
         if (keep) begin
            xdata[nexp] = w;
            xok[nexp]   = !(w == CA || w == CB);
            xsos[nexp]  = (d == 0) && (bcnt == 0);
            nexp++;
         end
      end
      bcnt = (bcnt + 1 >= int'(fps_limit)) ? 0 : bcnt + 1;
      fidx++;
   endtask

   task automatic good_frame(input bit keep);
      add_frame(SYNC, 32'(bcnt), keep);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; enable = 1'b0; in_valid = 1'b0; out_ready = 1'b0; in_data = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic run(input int limit);
      int idx = 0;
      int oidx = 0;
      sos_seen = 0;
      enable = 1'b1;
      for (int c = 0; c < limit; c++) begin
         @(negedge clk);
         in_valid  = (idx < nstim) && ($urandom % 4 != 0);
         in_data   = (idx < nstim) ? stim[idx] : 32'h0;
         out_ready = ($urandom % 3 != 0);
         #1;
         if (sos_irq) sos_seen++;
         if (out_valid && out_ready) begin
            if (oidx < nexp) begin
               chk(out_data == xdata[oidx], "R1 R11 data order", out_data, xdata[oidx]);
               chk(out_ok == xok[oidx], "R6 validity tag", out_ok, xok[oidx]);
               chk(out_sos == xsos[oidx], "R10 second tag", out_sos, xsos[oidx]);
            end else begin
               chk(1'b0, "R5 extra output word", out_data, 0);
            end
            oidx++;
         end
         if (in_valid && in_ready) idx++;
         if (idx == nstim && oidx == nexp && !out_valid) break;
      end
      @(negedge clk);
      in_valid = 1'b0; out_ready = 1'b1;
      repeat (3) @(negedge clk);
      chk(oidx == nexp, "R11 word count", oidx, nexp);
   endtask

   initial begin
      void'($urandom(7321));
      fps_limit = 16'd3;
      do_reset();
      #1;
      chk(out_valid == 1'b0 && hdr_err == 1'b0 && sec_count == 0, "reset state",
          {out_valid, hdr_err, sec_count}, 0);
      // R12: disabled block takes nothing
      in_valid = 1'b1; in_data = SYNC;
      repeat (4) @(negedge clk);
      #1;
      chk(in_ready == 1'b0, "R12 gate while disabled", in_ready, 0);
      in_valid = 1'b0;

      // One frame: seconds counter reads 1, time codes captured (R9, R8)
      clear_stream(); good_frame(1'b1);
      run(200);
      chk(sec_count == 1, "R9 first second", sec_count, 1);
      chk(tcode0 == 32'h7100_0000, "R8 tcode0 first", tcode0, 32'h7100_0000);
      chk(tcode1 == 32'h7100_0001, "R8 tcode1 first", tcode1, 32'h7100_0001);

      // Long clean run with sentinel headers, wraps at 3 (R3, R7, R8)
      do_reset(); clear_stream();
      good_frame(1'b1); good_frame(1'b1); good_frame(1'b1); good_frame(1'b1);
      add_frame(CA, 32'(bcnt), 1'b1);   // frame 4: sync replaced
      add_frame(SYNC, CB, 1'b1);        // frame 5: count replaced
      add_frame(SYNC, CA, 1'b1);        // frame 6: count-0 replaced
      good_frame(1'b1);
      run(1000);
      chk(hdr_err == 1'b0, "R7 sentinel headers accepted", hdr_err, 0);
      chk(hdr_err == 1'b0, "R3 wrap after limit accepted", hdr_err, 0);
      chk(sec_count == 3, "R9 seconds after eight frames", sec_count, 3);
      chk(sos_seen == 3, "R8 interrupt pulses", sos_seen, 3);
      chk(tcode0 == 32'h7100_000C, "R8 tcode0 from counter-found frame", tcode0, 32'h7100_000C);
      chk(tcode1 == 32'h7100_000D, "R8 tcode1 from counter-found frame", tcode1, 32'h7100_000D);

      // Bad sync on second frame (R2, R5)
      do_reset(); clear_stream();
      good_frame(1'b1);
      add_frame(SYNC ^ 32'h1, 32'd1, 1'b0);
      good_frame(1'b0);
      run(300);
      #1;
      chk(hdr_err == 1'b1, "R2 bad sync flagged", hdr_err, 1);
      chk(err_led == 1'b1, "R5 lamp on", err_led, 1);
      in_valid = 1'b1; #1;
      chk(in_ready == 1'b0, "R5 input halted", in_ready, 0);
      in_valid = 1'b0;

      // First frame carries count 1 (R4)
      do_reset(); clear_stream();
      add_frame(SYNC, 32'd1, 1'b0);
      run(200);
      chk(hdr_err == 1'b1, "R4 nonzero first count", hdr_err, 1);
      chk(sec_count == 0, "R4 no second counted", sec_count, 0);

      // Skipped count (R3)
      do_reset(); clear_stream();
      good_frame(1'b1);
      add_frame(SYNC, 32'd2, 1'b0);
      run(300);
      chk(hdr_err == 1'b1, "R3 skipped count", hdr_err, 1);

      // Late wrap: count 3 where 0 is due (R3)
      do_reset(); clear_stream();
      good_frame(1'b1); good_frame(1'b1); good_frame(1'b1);
      add_frame(SYNC, 32'd3, 1'b0);
      run(500);
      chk(hdr_err == 1'b1, "R3 missing wrap", hdr_err, 1);
      chk(sec_count == 1, "R9 count before error", sec_count, 1);

      finish_up();
   end
endmodule